// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block lets CPU software write one byte at a time into the upper bank of an on-chip flash array. Software sees it as three byte-wide registers. One is a key register that arms a short unlock window. One is a control/status register that holds a 4-bit command code and two read-only flags, `busy` and `error`. One is a data port. The block contains a behavioural flash array. The array has a fixed per-operation latency and a fault input, which a test can use to make an operation fail.

To program a byte, software first unlocks the control register. It then loads command `0xB`, which arms an upper-bank write. Next it writes the address high byte, the address low byte and the data byte, in that order, to the data port. The third write starts the operation; there is no separate go bit. The `busy` flag idles at 1. It stays at 1 through a programmable start delay, then drops to 0 while the array works, and returns to 1 when the operation ends. A target below the bank boundary, or outside the array, is refused. A fault from the array aborts the operation and sets `error`. Each command serves a single operation. After that operation, software must load the command again.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the control register reads `0x80`: `busy` is bit 7 and equals 1, `error` is bit 6 and equals 0, and the command field in bits 3:0 is 0.
- R2: A control write that does not fall in an open unlock window leaves the control register unchanged.
- R3: The unlock sequence is `0xAA` written to the key register, followed on the next cycle by `0x55`. A control write is accepted on any of the 3 clocks after the `0x55` write, and not on the 4th. Each window accepts only one control write.
- R4: Data-port writes are ignored unless command `0xB` is loaded: no operation starts and the array is unchanged.
- R5: With command `0xB` loaded, three data-port writes program the array. The writes are, in order, address bits 15:8, address bits 7:0, and the data byte. The operation starts without any further write.
- R6: `busy` drops START_DLY+1 clocks after the third data-port write. It stays at 0 for exactly OP_LAT clocks and then returns to 1.
- R7: When an operation ends, its command is consumed. Later data-port writes are ignored until an accepted control write loads `0xB` again.
- R8: A target address below BANK_BASE, or at or above 2^ADDR_W, is refused. `error` is set, `busy` never drops, and the array is unchanged.
- R9: A fault raised during an operation aborts it. `busy` returns to 1, `error` is set, and the byte is not written.
- R10: An accepted control write clears `error`.
- R11: A control write made while `busy` is 0 is discarded, even if it falls inside an unlock window.
- R12: Software cannot change bits 7:6 of the control register. An accepted write with those bits set loads only the command field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 key, 1 control, 2 data port |
| reg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control/status readback: {busy, error, 2'b00, command} |
| flash_fault | input | 1 | Fault input to the flash array |
| peek_addr | input | ADDR_W | Array read address |
| peek_data | output | 8 | Array read data (erased value `0xFF`) |

## Verification
The bench builds the block with ADDR_W=11, BANK_BASE=0x400, START_DLY=5 and OP_LAT=4. With these values the bench can measure the exact start delay and the exact length of the busy-low phase. The small array also makes two kinds of refused target reachable with plain 16-bit addresses: one below the bank boundary and one beyond the end of the array. The short latencies leave room to inject a fault, and to attempt a control write, during the busy-low phase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [1:0] SEL_KEY  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam logic [3:0] CMD_WRITE_UPPER = 4'hB;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_DELAY = 2'd2,
        SQ_RUN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fps_unlock.sv
module fps_unlock #(
    parameter int WINDOW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       ctrl_try,
    output logic       win_open
);
    import flash_seq_pkg::*;

    localparam int WIN_W = $clog2(WINDOW + 1);

    typedef struct packed {
        logic             first_seen;
        logic [WIN_W-1:0] remain;
    } unlock_t;

    unlock_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.first_seen = key_wr && (key_data == KEY_FIRST);
        if (key_wr && s_q.first_seen && (key_data == KEY_SECOND)) begin
            s_d.remain = WIN_W'(WINDOW);
        end else if (ctrl_try && (s_q.remain != '0)) begin
            s_d.remain = '0;
        end else if (s_q.remain != '0) begin
            s_d.remain = s_q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win_open = (s_q.remain != '0);

endmodule

// File: rtl/fps_bank_guard.sv
module fps_bank_guard #(
    parameter int ADDR_W    = 11,
    parameter int BANK_BASE = 1 << (ADDR_W - 1)
) (
    input  logic [15:0] target,
    output logic        allowed
);
    localparam int DEPTH = 1 << ADDR_W;

    logic above_base;
    logic inside_array;

    always_comb begin
        above_base   = (int'(target) >= BANK_BASE);
        inside_array = (int'(target) < DEPTH);
        allowed      = above_base && inside_array;
    end

endmodule

// File: rtl/fps_array.sv
module fps_array #(
    parameter int ADDR_W = 11,
    parameter int OP_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              fault,
    output logic              done,
    output logic              fail,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LAT_W = (OP_LAT > 1) ? $clog2(OP_LAT) : 1;

    typedef struct packed {
        logic              active;
        logic [LAT_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } op_t;

    op_t  o_d, o_q;
    logic commit;
    logic [7:0] cells [DEPTH];

    always_comb begin
        o_d    = o_q;
        done   = 1'b0;
        fail   = 1'b0;
        commit = 1'b0;
        if (o_q.active) begin
            if (fault) begin
                done     = 1'b1;
                fail     = 1'b1;
                o_d.active = 1'b0;
            end else if (o_q.left == '0) begin
                done     = 1'b1;
                commit   = 1'b1;
                o_d.active = 1'b0;
            end else begin
                o_d.left = o_q.left - 1'b1;
            end
        end else if (start) begin
            o_d.active = 1'b1;
            o_d.left   = LAT_W'(OP_LAT - 1);
            o_d.addr   = addr;
            o_d.data   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (commit) begin
            cells[o_q.addr] <= o_q.data;
        end
    end

    assign peek_data = cells[peek_addr];

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
    parameter int ADDR_W    = 11,
    parameter int BANK_BASE = 1 << (ADDR_W - 1),
    parameter int START_DLY = 1000,
    parameter int OP_LAT    = 4,
    parameter int UNLOCK_WIN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        ctrl_rdata,
    input  logic              flash_fault,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data
);
    import flash_seq_pkg::*;

    localparam int CNT_W = (START_DLY > 0) ? $clog2(START_DLY + 1) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [3:0]       cmd;
        logic             busy;
        logic             err;
        logic [1:0]       nbytes;
        logic [7:0]       addr_hi;
        logic [7:0]       addr_lo;
        logic [7:0]       data;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    logic        key_wr, ctrl_wr, data_wr;
    logic        win_open;
    logic        ctrl_take;
    logic        target_ok;
    logic [15:0] op_addr;
    logic        arr_start, arr_done, arr_fail;

    assign key_wr  = reg_wr && (reg_sel == SEL_KEY);
    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign op_addr = {s_q.addr_hi, s_q.addr_lo};

    fps_unlock #(.WINDOW(UNLOCK_WIN)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (reg_wdata),
        .ctrl_try (ctrl_wr),
        .win_open (win_open)
    );

    fps_bank_guard #(.ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE)) u_guard (
        .target  (op_addr),
        .allowed (target_ok)
    );

    fps_array #(.ADDR_W(ADDR_W), .OP_LAT(OP_LAT)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (arr_start),
        .addr      (op_addr[ADDR_W-1:0]),
        .wdata     (s_q.data),
        .fault     (flash_fault),
        .done      (arr_done),
        .fail      (arr_fail),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // A control write is taken only inside a window and while no
    // operation is pending or running.
    assign ctrl_take = ctrl_wr && win_open &&
                       ((s_q.state == SQ_IDLE) || (s_q.state == SQ_ARMED));

    always_comb begin
        s_d       = s_q;
        arr_start = 1'b0;
        unique case (s_q.state)
            SQ_IDLE, SQ_ARMED: begin
                if (ctrl_take) begin
                    s_d.cmd    = reg_wdata[3:0];
                    s_d.err    = 1'b0;
                    s_d.nbytes = '0;
                    s_d.state  = (reg_wdata[3:0] == CMD_WRITE_UPPER) ? SQ_ARMED : SQ_IDLE;
                end else if (data_wr && (s_q.state == SQ_ARMED)) begin
                    unique case (s_q.nbytes)
                        2'd0: begin
                            s_d.addr_hi = reg_wdata;
                            s_d.nbytes  = 2'd1;
                        end
                        2'd1: begin
                            s_d.addr_lo = reg_wdata;
                            s_d.nbytes  = 2'd2;
                        end
                        default: begin
                            s_d.data   = reg_wdata;
                            s_d.nbytes = '0;
                            if (target_ok) begin
                                s_d.state = SQ_DELAY;
                                s_d.cnt   = CNT_W'(START_DLY);
                            end else begin
                                s_d.err   = 1'b1;
                                s_d.state = SQ_IDLE;
                            end
                        end
                    endcase
                end
            end
            SQ_DELAY: begin
                if (s_q.cnt == '0) begin
                    arr_start = 1'b1;
                    s_d.busy  = 1'b0;
                    s_d.state = SQ_RUN;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SQ_RUN: begin
                if (arr_done) begin
                    s_d.busy  = 1'b1;
                    s_d.err   = arr_fail;
                    s_d.state = SQ_IDLE;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= SQ_IDLE;
            s_q.busy  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl_rdata = {s_q.busy, s_q.err, 2'b00, s_q.cmd};

endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
    parameter int BANK_BASE = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [7:0]  ctrl_rdata,
    input logic        win_open,
    input logic        arr_start,
    input logic        arr_done,
    input logic        arr_fail,
    input logic [15:0] op_addr
);
    assert_ctrl_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && !win_open) |=> $stable(ctrl_rdata[3:0]));

    assert_ctrl_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && !ctrl_rdata[7]) |=> $stable(ctrl_rdata[3:0]));

    assert_start_drops_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !ctrl_rdata[7]);

    assert_busy_falls_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rdata[7]) |-> $past(arr_start));

    assert_done_restores_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_done |=> ctrl_rdata[7]);

    assert_fault_sets_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_done && arr_fail) |=> ctrl_rdata[6]);

    assert_upper_bank_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> (int'(op_addr) >= BANK_BASE));

endmodule

bind flash_prog_seq flash_prog_seq_chk #(.BANK_BASE(BANK_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .ctrl_rdata (ctrl_rdata),
    .win_open   (win_open),
    .arr_start  (arr_start),
    .arr_done   (arr_done),
    .arr_fail   (arr_fail),
    .op_addr    (op_addr)
);

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;

    localparam int AW    = 11;
    localparam int BASE  = 'h400;
    localparam int SDLY  = 5;
    localparam int OPLAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    ctrl_rdata;
    logic          flash_fault = 1'b0;
    logic [AW-1:0] peek_addr = '0;
    logic [7:0]    peek_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    flash_prog_seq #(.ADDR_W(AW), .BANK_BASE(BASE), .START_DLY(SDLY), .OP_LAT(OPLAT)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .flash_fault(flash_fault),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic unlock_ctrl(logic [7:0] c);
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        wr(2'd1, c);
    endtask

    task automatic peek(int a, output logic [7:0] v);
        peek_addr = AW'(a);
        #1 v = peek_data;
    endtask

    task automatic send_bytes(int a, logic [7:0] d);
        wr(2'd2, 8'(a >> 8));
        wr(2'd2, 8'(a));
        wr(2'd2, d);
    endtask

    task automatic wait_busy_high(output int low_cycles);
        low_cycles = 0;
        while (ctrl_rdata[7] == 1'b0 && low_cycles < 100) begin
            @(negedge clk);
            low_cycles++;
        end
    endtask

    task automatic t_reset;
        check("R1 reset value", ctrl_rdata, 'h80);
    endtask

    task automatic t_locked;
        logic [7:0] v;
        wr(2'd1, 8'h0B);
        idle(1);
        check("R2 control write without unlock", ctrl_rdata, 'h80);
        send_bytes('h500, 8'h77);
        idle(SDLY + 3);
        check("R4 busy unchanged with no command", ctrl_rdata[7], 1);
        peek('h500, v);
        check("R4 array untouched with no command", v, 'hFF);
    endtask

    task automatic t_window;
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        idle(3);
        wr(2'd1, 8'h0B);
        check("R3 write on 4th clock discarded", ctrl_rdata[3:0], 0);
        wr(2'd0, 8'h55);
        wr(2'd0, 8'hAA);
        wr(2'd1, 8'h0B);
        check("R3 reversed keys discarded", ctrl_rdata[3:0], 0);
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        idle(2);
        wr(2'd1, 8'h0B);
        check("R3 write on 3rd clock accepted", ctrl_rdata[3:0], 'hB);
        wr(2'd1, 8'h03);
        check("R3 one write per window", ctrl_rdata[3:0], 'hB);
    endtask

    task automatic t_program;
        int k, lowc;
        logic [7:0] v;
        unlock_ctrl(8'hCB);
        check("R12 flag bits not writable", ctrl_rdata, 'h8B);
        send_bytes('h512, 8'h5A);
        k = 0;
        while (ctrl_rdata[7] == 1'b1 && k < 100) begin
            @(negedge clk);
            k++;
        end
        check("R6 start delay", k, SDLY + 1);
        wait_busy_high(lowc);
        check("R6 busy low length", lowc, OPLAT);
        peek('h512, v);
        check("R5 byte programmed", v, 'h5A);
        check("R5 no error", ctrl_rdata[6], 0);
        send_bytes('h513, 8'h22);
        idle(SDLY + 2);
        check("R7 busy stays high after consumption", ctrl_rdata[7], 1);
        peek('h513, v);
        check("R7 consumed command ignores data", v, 'hFF);
    endtask

    task automatic t_lower;
        logic [7:0] v;
        int lowseen;
        unlock_ctrl(8'h0B);
        send_bytes('h010, 8'h11);
        lowseen = 0;
        for (int i = 0; i < SDLY + OPLAT + 4; i++) begin
            @(negedge clk);
            if (!ctrl_rdata[7]) lowseen = 1;
        end
        check("R8 busy never drops for lower bank", lowseen, 0);
        check("R8 error set for lower bank", ctrl_rdata[6], 1);
        peek('h010, v);
        check("R8 lower bank unchanged", v, 'hFF);
        unlock_ctrl(8'h0B);
        check("R10 error cleared by command", ctrl_rdata[6], 0);
        send_bytes('h900, 8'h44);
        idle(SDLY + OPLAT + 4);
        check("R8 address beyond array refused", ctrl_rdata, 'hCB);
        peek('h100, v);
        check("R8 folded location unchanged", v, 'hFF);
    endtask

    task automatic t_fault;
        int lowc;
        logic [7:0] v;
        unlock_ctrl(8'h0B);
        check("R10 error cleared again", ctrl_rdata[6], 0);
        send_bytes('h600, 8'h33);
        while (ctrl_rdata[7] == 1'b1) @(negedge clk);
        flash_fault = 1'b1;
        @(negedge clk);
        flash_fault = 1'b0;
        check("R9 busy back high after fault", ctrl_rdata[7], 1);
        check("R9 error set after fault", ctrl_rdata[6], 1);
        idle(OPLAT + 1);
        peek('h600, v);
        check("R9 byte not written", v, 'hFF);
        wait_busy_high(lowc);
    endtask

    task automatic t_busy_ctrl;
        int lowc;
        logic [7:0] v;
        unlock_ctrl(8'h0B);
        send_bytes('h7FF, 8'hC3);
        while (ctrl_rdata[7] == 1'b1) @(negedge clk);
        wr(2'd0, 8'hAA);
        wr(2'd0, 8'h55);
        wr(2'd1, 8'h02);
        check("R11 control write while busy discarded", ctrl_rdata[3:0], 'hB);
        wait_busy_high(lowc);
        check("R11 command field after operation", ctrl_rdata[3:0], 'hB);
        peek('h7FF, v);
        check("R5 top byte of bank programmed", v, 'hC3);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst_n = 1'b1;
                idle(2);
                t_reset();
                t_locked();
                t_window();
                t_program();
                t_lower();
                t_fault();
                t_busy_ctrl();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule